// File: doc/BRIEF.md
# Indirect extended register access

This block is the register-file side of a PHY management port. Only two 16-bit words are reachable directly: a control word and a data word. Through them the host reaches a larger extended register space. The host first puts an access type and a target device number into the control word. It then writes an extended register number into the data word. Finally it switches the access type to one of the data modes, after which reads and writes of the data word reach the extended register that the held pointer selects.

There are three data modes. The first leaves the pointer where it is. The second advances it by one after every data access. The third advances it only after a data write. The extended space belongs to the vendor device, number 0x1F. It holds ten 8-bit registers at extended addresses 0x1E0 to 0x1E9. Each register sits in the low byte of a 16-bit word. The serial framing of the management bus sits outside the block. The block sees a simple parallel access port with a one-cycle read latency.

Top module: `ext_reg_access`

## Requirements
- R1: After reset the control word reads 0x0000, the pointer is 0x0000, and the extended registers at 0x1E0..0x1E9 hold 0xC5, 0x67, 0x70, 0x03, 0x20, 0x00, 0x40, 0x00, 0x40, 0x20 in ascending address order.
- R2: The control word is at direct address 0x0D. Bits 15:14 hold the access type and bits 4:0 hold the device number. Bits 13:5 ignore writes and read as zero.
- R3: The data word is at direct address 0x0E. With access type 0 (address), a write to it loads the full 16-bit pointer, and a read of it returns the pointer.
- R4: With access type 1 (data), a read of the data word returns the extended register at the pointer. A write replaces it. The pointer does not move.
- R5: With access type 2, the pointer advances by one after each data-word read and after each data-word write.
- R6: With access type 3, the pointer advances by one after each data-word write and holds across data-word reads.
- R7: In any data mode, when the device number is not 0x1F, a data-word read returns zero and a data-word write changes no extended register.
- R8: Bits 15:8 of a data-word write in a data mode are dropped. Those bits always read back zero.
- R9: In a data mode, a pointer outside 0x1E0..0x1E9 reads as zero, and writes through it change nothing.
- R10: Any direct address other than 0x0D and 0x0E reads as zero, and writes to it change neither word.
- R11: A read issued in cycle N returns its data with reg_rvalid high in cycle N+1 only. Read data reflects the state before any pointer advance that the same access causes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 5 | Direct register address |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, held until the next read |
| reg_rvalid | output | 1 | High for the cycle after a read strobe |

## Verification
The assertions take it that the host never raises the read and write strobes in the same cycle. Under that condition, each strobe counts as exactly one data access for the pointer-advance rules. The bench issues one access at a time and leaves an idle cycle after each strobe, so this condition always holds. Every access also sits on a stable address and data for its whole strobe cycle.

// File: rtl/ext_pkg.sv
package ext_pkg;

  typedef enum logic [1:0] {
    ACC_ADDR     = 2'd0,
    ACC_DATA     = 2'd1,
    ACC_DATA_INC = 2'd2,
    ACC_DATA_WRI = 2'd3
  } acc_t;

  // power-up contents of the extended bank, by index from its base
  function automatic logic [15:0] ext_reset_value(input int unsigned idx);
    logic [15:0] v;
    case (idx)
      0:       v = 16'h00C5;
      1:       v = 16'h0067;
      2:       v = 16'h0070;
      3:       v = 16'h0003;
      4:       v = 16'h0020;
      5:       v = 16'h0000;
      6:       v = 16'h0040;
      7:       v = 16'h0000;
      8:       v = 16'h0040;
      9:       v = 16'h0020;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ira_reset_sync.sv
module ira_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_r[STAGES-1];
endmodule

// File: rtl/ira_ctl_reg.sv
module ira_ctl_reg
  import ext_pkg::*;
#(
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  acc_t             type_in,
  input  logic [DEV_W-1:0] dev_in,
  output acc_t             acc_type,
  output logic [DEV_W-1:0] dev_addr
);
  acc_t             type_r, type_nxt;
  logic [DEV_W-1:0] dev_r, dev_nxt;

  always_comb begin
    type_nxt = type_r;
    dev_nxt  = dev_r;
    if (wr_en) begin
      type_nxt = type_in;
      dev_nxt  = dev_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_r <= ACC_ADDR;
      dev_r  <= '0;
    end else if (wr_en) begin
      type_r <= type_nxt;
      dev_r  <= dev_nxt;
    end
  end

  assign acc_type = type_r;
  assign dev_addr = dev_r;
endmodule

// File: rtl/ira_addr_ptr.sv
module ira_addr_ptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_r, ptr_nxt;
  logic             ptr_en;

  assign ptr_en = load | inc;

  always_comb begin
    ptr_nxt = ptr_r;
    if (load)     ptr_nxt = load_val;
    else if (inc) ptr_nxt = ptr_r + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_r <= '0;
    else if (ptr_en) ptr_r <= ptr_nxt;
  end

  assign ptr = ptr_r;
endmodule

// File: rtl/ira_ext_file.sv
module ira_ext_file
  import ext_pkg::*;
#(
  parameter int               REG_W     = 16,
  parameter int               EXT_W     = 8,
  parameter int               EXT_COUNT = 10,
  parameter logic [REG_W-1:0] EXT_BASE  = 16'h01E0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] ptr,
  input  logic [EXT_W-1:0] wdata,
  output logic [EXT_W-1:0] rd_val
);
  localparam int BANK_W = EXT_COUNT * EXT_W;

  logic [REG_W-1:0]  off;
  logic              hit;
  logic [BANK_W-1:0] bank;

  assign off = ptr - EXT_BASE;
  assign hit = (ptr >= EXT_BASE) && (off < REG_W'(EXT_COUNT));

  for (genvar i = 0; i < EXT_COUNT; i++) begin : g_reg
    logic             sel;
    logic             en;
    logic [EXT_W-1:0] q_r, q_nxt;

    assign sel = hit && (off == REG_W'(i));
    assign en  = we && sel;

    always_comb begin
      q_nxt = q_r;
      if (en) q_nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_r <= EXT_W'(ext_reset_value(i));
      else if (en) q_r <= q_nxt;
    end

    assign bank[i*EXT_W +: EXT_W] = q_r;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < EXT_COUNT; i++) begin
      if (hit && (off == REG_W'(i))) rd_val = bank[i*EXT_W +: EXT_W];
    end
  end
endmodule

// File: rtl/ext_reg_access.sv
module ext_reg_access
  import ext_pkg::*;
#(
  parameter int                 REG_W      = 16,
  parameter int                 DADDR_W    = 5,
  parameter int                 DEV_W      = 5,
  parameter int                 EXT_W      = 8,
  parameter int                 EXT_COUNT  = 10,
  parameter logic [DADDR_W-1:0] CTL_ADDR   = 5'h0D,
  parameter logic [DADDR_W-1:0] DATA_ADDR  = 5'h0E,
  parameter logic [DEV_W-1:0]   VENDOR_DEV = 5'h1F,
  parameter logic [REG_W-1:0]   EXT_BASE   = 16'h01E0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DADDR_W-1:0] reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               reg_rvalid
);
  localparam int TYPE_W = 2;
  localparam int GAP_W  = REG_W - TYPE_W - DEV_W;
  localparam int PAD_W  = REG_W - EXT_W;

  logic             rst_sync_n;
  acc_t             acc_type;
  logic [DEV_W-1:0] dev_addr;
  logic [REG_W-1:0] ptr;
  logic [EXT_W-1:0] ext_val;

  logic sel_ctl, sel_data, data_mode, vendor;
  logic wr_go, rd_go;
  logic ctl_we, ptr_load, ptr_inc, data_acc, ext_we;

  logic [REG_W-1:0] rdata_r, rdata_nxt;
  logic             rvalid_r, rvalid_nxt;

  ira_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // access decode; a write wins if both strobes appear together
  assign sel_ctl   = (reg_addr == CTL_ADDR);
  assign sel_data  = (reg_addr == DATA_ADDR);
  assign wr_go     = reg_wr;
  assign rd_go     = reg_rd & ~reg_wr;
  assign data_mode = (acc_type != ACC_ADDR);
  assign vendor    = (dev_addr == VENDOR_DEV);

  assign ctl_we   = wr_go & sel_ctl;
  assign ptr_load = wr_go & sel_data & ~data_mode;
  assign data_acc = sel_data & data_mode & (wr_go | rd_go);
  assign ptr_inc  = data_acc & ((acc_type == ACC_DATA_INC) |
                                ((acc_type == ACC_DATA_WRI) & wr_go));
  assign ext_we   = wr_go & sel_data & data_mode & vendor;

  ira_ctl_reg #(.DEV_W(DEV_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (ctl_we),
    .type_in  (acc_t'(reg_wdata[REG_W-1 -: TYPE_W])),
    .dev_in   (reg_wdata[DEV_W-1:0]),
    .acc_type (acc_type),
    .dev_addr (dev_addr)
  );

  ira_addr_ptr #(.PTR_W(REG_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (ptr_load),
    .inc      (ptr_inc),
    .load_val (reg_wdata),
    .ptr      (ptr)
  );

  ira_ext_file #(
    .REG_W     (REG_W),
    .EXT_W     (EXT_W),
    .EXT_COUNT (EXT_COUNT),
    .EXT_BASE  (EXT_BASE)
  ) u_ext (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (ext_we),
    .ptr    (ptr),
    .wdata  (reg_wdata[EXT_W-1:0]),
    .rd_val (ext_val)
  );

  // read path: value formed from state before this cycle's updates
  always_comb begin
    rdata_nxt  = rdata_r;
    rvalid_nxt = rd_go;
    if (rd_go) begin
      rdata_nxt = '0;
      if (sel_ctl) begin
        rdata_nxt = {acc_type, {GAP_W{1'b0}}, dev_addr};
      end else if (sel_data) begin
        if (!data_mode)  rdata_nxt = ptr;
        else if (vendor) rdata_nxt = {{PAD_W{1'b0}}, ext_val};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_r <= '0;
    else if (rd_go)  rdata_r <= rdata_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_r <= 1'b0;
    else             rvalid_r <= rvalid_nxt;
  end

  assign reg_rdata  = rdata_r;
  assign reg_rvalid = rvalid_r;
endmodule

// File: rtl/ira_checker.sv
module ira_checker #(
  parameter int                 REG_W      = 16,
  parameter int                 DADDR_W    = 5,
  parameter int                 DEV_W      = 5,
  parameter int                 EXT_W      = 8,
  parameter logic [DADDR_W-1:0] CTL_ADDR   = 5'h0D,
  parameter logic [DADDR_W-1:0] DATA_ADDR  = 5'h0E,
  parameter logic [DEV_W-1:0]   VENDOR_DEV = 5'h1F
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DADDR_W-1:0] reg_addr,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [REG_W-1:0]   reg_wdata,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               reg_rvalid,
  input logic [1:0]         acc_type,
  input logic [DEV_W-1:0]   dev_addr,
  input logic [REG_W-1:0]   ptr
);
  logic rd_only, data_hit;
  assign rd_only  = reg_rd && !reg_wr;
  assign data_hit = (reg_addr == DATA_ADDR) && (reg_wr || reg_rd);

  p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  p_rvalid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_only |=> reg_rvalid);

  p_rvalid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_only |=> !reg_rvalid);

  p_ctl_gap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && reg_addr == CTL_ADDR) |=> (reg_rdata[REG_W-3:DEV_W] == '0));

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == DATA_ADDR && acc_type == 2'd0) |=> (ptr == $past(reg_wdata)));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && acc_type == 2'd1) |=> $stable(ptr));

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && acc_type == 2'd2) |=> (ptr == $past(ptr) + REG_W'(1)));

  p_ptr_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && reg_addr == DATA_ADDR && acc_type == 2'd3) |=> $stable(ptr));

  p_other_dev_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && reg_addr == DATA_ADDR && acc_type != 2'd0 && dev_addr != VENDOR_DEV)
      |=> (reg_rdata == '0));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && reg_addr == DATA_ADDR && acc_type != 2'd0)
      |=> (reg_rdata[REG_W-1:EXT_W] == '0));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && reg_addr != DATA_ADDR && reg_addr != CTL_ADDR) |=> (reg_rdata == '0));
endmodule

bind ext_reg_access ira_checker #(
  .REG_W      (REG_W),
  .DADDR_W    (DADDR_W),
  .DEV_W      (DEV_W),
  .EXT_W      (EXT_W),
  .CTL_ADDR   (CTL_ADDR),
  .DATA_ADDR  (DATA_ADDR),
  .VENDOR_DEV (VENDOR_DEV)
) u_ira_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_addr   (reg_addr),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .acc_type   (acc_type),
  .dev_addr   (dev_addr),
  .ptr        (ptr)
);

// File: tb/ext_reg_access_bench.sv
module ext_reg_access_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTL  = 5'h0D;
  localparam logic [4:0] A_DATA = 5'h0E;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];

  logic [15:0] pwr_tab [10] = '{16'h00C5, 16'h0067, 16'h0070, 16'h0003, 16'h0020,
                                16'h0000, 16'h0040, 16'h0000, 16'h0040, 16'h0020};

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_reg_access u_ext_reg_access (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // monitor: pops expected values as read results appear
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: rvalid with no read pending, actual data %h expected none", reg_rdata);
      end else begin
        logic [15:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read data actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11: watchdog expired, actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state of control word and pointer
    n_checks++;
    if (reg_rvalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: rvalid after reset actual %b expected 0", reg_rvalid);
    end
    do_read(A_CTL,  16'h0000, "R1");
    do_read(A_DATA, 16'h0000, "R1");

    // R2: reserved control bits dropped
    do_write(A_CTL, 16'hFFFF);
    do_read(A_CTL, 16'hC01F, "R2");

    // R3: pointer load and read-back in address mode
    do_write(A_CTL, 16'h001F);
    do_write(A_DATA, 16'h01E0);
    do_read(A_DATA, 16'h01E0, "R3");

    // R1 and R5: walk the whole bank with increment on every access
    do_write(A_CTL, 16'h801F);
    for (int i = 0; i < 10; i++) do_read(A_DATA, pwr_tab[i], "R1");
    do_write(A_CTL, 16'h001F);
    do_read(A_DATA, 16'h01EA, "R5");

    // R4 and R8: plain data mode, pointer fixed
    do_write(A_DATA, 16'h01E0);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h00C5, "R4");
    do_read(A_DATA, 16'h00C5, "R4");
    do_write(A_DATA, 16'hAB5A);
    do_read(A_DATA, 16'h005A, "R8");
    do_write(A_CTL, 16'h001F);
    do_read(A_DATA, 16'h01E0, "R4");

    // R5: mixed reads and a write with increment on every access
    do_write(A_CTL, 16'h801F);
    do_read(A_DATA, 16'h005A, "R5");
    do_read(A_DATA, 16'h0067, "R5");
    do_read(A_DATA, 16'h0070, "R5");
    do_write(A_DATA, 16'h0011);
    do_write(A_CTL, 16'h001F);
    do_read(A_DATA, 16'h01E4, "R5");

    // R6: increment on writes only
    do_write(A_DATA, 16'h01E3);
    do_write(A_CTL, 16'hC01F);
    do_read(A_DATA, 16'h0011, "R6");
    do_read(A_DATA, 16'h0011, "R6");
    do_write(A_DATA, 16'h0022);
    do_read(A_DATA, 16'h0020, "R6");
    do_write(A_CTL, 16'h001F);
    do_read(A_DATA, 16'h01E4, "R6");
    do_write(A_DATA, 16'h01E3);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h0022, "R6");

    // R7: foreign device number
    do_write(A_CTL, 16'h4005);
    do_read(A_DATA, 16'h0000, "R7");
    do_write(A_DATA, 16'h00FF);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h0022, "R7");

    // R9: pointer outside the bank, both edges
    do_write(A_CTL, 16'h001F);
    do_write(A_DATA, 16'h01EA);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h0000, "R9");
    do_write(A_DATA, 16'h0055);
    do_read(A_DATA, 16'h0000, "R9");
    do_write(A_CTL, 16'h001F);
    do_write(A_DATA, 16'h01DF);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h0000, "R9");
    do_write(A_CTL, 16'h001F);
    do_write(A_DATA, 16'h01E9);
    do_write(A_CTL, 16'h401F);
    do_read(A_DATA, 16'h0020, "R9");

    // R10: unmapped direct address
    do_write(5'h00, 16'h1234);
    do_read(5'h00, 16'h0000, "R10");
    do_read(5'h1F, 16'h0000, "R10");
    do_read(A_CTL, 16'h401F, "R10");
    do_read(A_DATA, 16'h0020, "R10");

    repeat (3) @(negedge clk);
    // R11: every read produced exactly one result
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending reads actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule